// File: doc/BRIEF.md
# Real-Time Clock Register Interface with Alarm and Update Sequencing

This block is the byte-wide host interface of a real-time clock. The host reaches it through two ports. A write to the even port selects one of 128 byte locations, and the odd port then reads or writes the selected byte. Four locations are control and status registers: an oscillator/update control byte, a mode byte, a clear-on-read interrupt status byte and a fixed validity byte. All other locations are plain storage, and six of them hold the time of day and its alarm.

Seconds, minutes and hours are kept in an external binary counter. On every one-second tick, provided the oscillator field selects normal running, the block pulses that counter forward. It shows an update-in-progress bit for a fixed number of clocks. It then copies the counter into the visible time bytes in the selected encoding, compares the alarm bytes with the new time, and raises status flags and a level interrupt. When the host writes a time byte, the block decodes the byte and loads it back into the counter. A set-mode bit freezes the visible time, and no load is sent while it is set.

Top module: `rtc_regs`

## Requirements
- R1: A write with `sel_data_i`=0 stores the low 7 bits of the data as the index. A read with `sel_data_i`=0 returns 0xFF. With `sel_data_i`=1 the indexed byte is read or written.
- R2: After `rst_ni` the four registers read as follows: control A (index 10) = 0x26, mode B (index 11) = 0x02, status C (index 12) = 0x00, validity D (index 13) = 0x80. `irq_o` is low.
- R3: Writes to C and D have no effect. Bit 7 of A (update in progress) is not writable.
- R4: When B is written with bit 7 (set mode) = 1, A bit 7 is cleared and B bit 4 (update-ended enable) is stored as 0.
- R5: When `sec_tick_i` arrives and A bits 6:4 = 010, `step_o` pulses once. A bit 7 reads 1 from the next cycle on. UIP_LEAD cycles later, time bytes 0 (seconds), 2 (minutes) and 4 (hours) show the counter values and A bit 7 returns to 0.
- R6: When A bits 6:4 differ from 010, a tick causes no step, no update and no flag.
- R7: While B bit 7 = 1, updates leave the time bytes unchanged and time-byte writes send no load. Writing B with bit 7 = 0 while it was 1 sends one load of the stored time.
- R8: B bit 2 = 1 selects binary time bytes and 0 selects BCD. B bit 1 = 1 selects 24-hour hours. In 12-hour format the hour byte holds 1..12, with bit 7 = 1 for PM, so 0h reads 12 AM and 12h reads 12 PM.
- R9: Alarm bytes 1, 3 and 5 each match when their bits 7:6 are 11 or when they equal the encoded seconds, minutes or hours. When all three match at an update, C bit 5 is set. If B bit 5 is also set, C bit 7 is set and `irq_o` rises.
- R10: Every update sets C bit 4. If B bit 4 is set, C bit 7 is also set and `irq_o` rises.
- R11: A read of C returns its value, then clears it to 0 and drops `irq_o`. Until that read, `irq_o` stays high.
- R12: A `soft_rst_i` pulse clears B bits 6, 5 and 3 and all of C, and drops `irq_o`.
- R13: A `per_tick_i` pulse sets C bit 6. If B bit 6 is set, C bit 7 is also set and `irq_o` rises.
- R14: A write to byte 0, 2 or 4 outside set mode pulses `load_o` on the next cycle, carrying the decoded binary seconds, minutes and hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_data_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (a read of C has side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| sec_tick_i | input | 1 | One-second tick pulse |
| per_tick_i | input | 1 | Periodic-rate pulse from an external divider |
| soft_rst_i | input | 1 | Soft reset of enables and flags |
| cnt_sec_i | input | 6 | Counter seconds, binary |
| cnt_min_i | input | 6 | Counter minutes, binary |
| cnt_hour_i | input | 5 | Counter hours, binary 0..23 |
| step_o | output | 1 | Advance the counter by one second |
| load_o | output | 1 | Load the counter with the load values |
| load_sec_o | output | 6 | Seconds to load, binary |
| load_min_o | output | 6 | Minutes to load, binary |
| load_hour_o | output | 5 | Hours to load, binary 0..23 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the hour wraps in 12-hour mode (11 PM to 12 AM and 11 AM to 12 PM). A design that gets these wrong shows 0x00 or leaves the PM bit in the wrong state. It writes set mode while an update is under way, so a design that leaves the update-in-progress bit high is caught. It also checks that a frozen update still raises the update-ended flag without an interrupt, that don't-care alarm bytes match every second, and that the interrupt stays high until status is read. Any of these errors would show up as a lost or stray flag, or as a stuck interrupt.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int IX_SEC = 0, IX_SEC_AL = 1, IX_MIN = 2, IX_MIN_AL = 3;
  localparam int IX_HR = 4, IX_HR_AL = 5;
  localparam int IX_CTL_A = 10, IX_CTL_B = 11, IX_STAT = 12, IX_VALID = 13;
  localparam int A_UIP = 7;
  localparam int B_SET = 7, B_PER = 6, B_ALM = 5, B_UPD = 4, B_SQW = 3, B_BIN = 2, B_H24 = 1;
  localparam int S_ANY = 7, S_PER = 6, S_ALM = 5, S_UPD = 4;
  localparam logic [7:0] A_RST = 8'h26, B_RST = 8'h02, D_RST = 8'h80;
  localparam logic [2:0] OSC_RUN = 3'b010;

  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [3:0] t, o;
    t = 4'(v / 7'd10);
    o = 4'(v % 7'd10);
    return bin ? {1'b0, v} : {t, o};
  endfunction

  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    logic [6:0] r;
    r = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    return bin ? b[6:0] : r;
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    if (h24) return enc_val({2'b0, h}, bin);
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    return {h >= 5'd12, 7'(enc_val({2'b0, h12}, bin))};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] h;
    h = dec_val({1'b0, b[6:0]}, bin);
    if (!h24) begin
      if (h == 7'd12) h = 7'd0;
      if (b[7]) h = h + 7'd12;
    end
    return 5'(h);
  endfunction
endpackage

// File: rtl/rtc_port_dec.sv
module rtc_port_dec #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             data_wr_o,
  output logic             data_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_o <= '0;
    else if (wr_i && !sel_i) idx_o <= wdata_i[IDX_W-1:0];
  end

  assign data_wr_o = wr_i & sel_i;
  assign data_rd_o = rd_i & sel_i;
endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int LEAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  output logic step_o,
  output logic start_o,
  output logic refresh_o
);
  localparam int CNT_W = $clog2(LEAD + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o   = (st_q == ST_IDLE) && tick_i && run_i;
  assign refresh_o = (st_q == ST_WAIT) && (cnt_q == '0);

  // counter steps one cycle after start; refresh waits LEAD edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      step_o <= 1'b0;
    end else begin
      step_o <= start_o;
      if (start_o) begin
        st_q  <= ST_WAIT;
        cnt_q <= CNT_W'(LEAD - 1);
      end else if (refresh_o) begin
        st_q <= ST_IDLE;
      end else if (st_q == ST_WAIT) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N = 3
) (
  input  logic [N-1:0][7:0] alarm_i,
  input  logic [N-1:0][7:0] now_i,
  output logic              hit_o
);
  logic [N-1:0] fld_hit;

  for (genvar g = 0; g < N; g++) begin : g_fld
    assign fld_hit[g] = (alarm_i[g][7:6] == 2'b11) || (alarm_i[g] == now_i[g]);
  end

  assign hit_o = &fld_hit;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int UIP_LEAD = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_data_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sec_tick_i,
  input  logic       per_tick_i,
  input  logic       soft_rst_i,
  input  logic [5:0] cnt_sec_i,
  input  logic [5:0] cnt_min_i,
  input  logic [4:0] cnt_hour_i,
  output logic       step_o,
  output logic       load_o,
  output logic [5:0] load_sec_o,
  output logic [5:0] load_min_o,
  output logic [4:0] load_hour_o,
  output logic       irq_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_SEC = IDX_W'(IX_SEC), I_MIN = IDX_W'(IX_MIN), I_HR = IDX_W'(IX_HR);
  localparam logic [IDX_W-1:0] I_A = IDX_W'(IX_CTL_A), I_B = IDX_W'(IX_CTL_B);
  localparam logic [IDX_W-1:0] I_C = IDX_W'(IX_STAT), I_D = IDX_W'(IX_VALID);
  localparam logic [7:0] SOFT_CLR = 8'h68;

  logic [IDX_W-1:0] idx;
  logic             data_wr, data_rd;
  logic [7:0]       mem [DEPTH];
  logic [7:0]       a_q, b_q, c_q, d_q;
  logic             irq_q, load_q;
  logic             start, refresh, osc_run, alarm_hit, c_rd;
  logic [7:0]       now_sec, now_min, now_hr;
  logic [7:0]       a_next, b_next, c_next, wr_b;
  logic             irq_next, irq_evt, load_next, is_time, is_ctl;

  rtc_port_dec #(.IDX_W(IDX_W)) u_port (
    .clk_i, .rst_ni, .sel_i(sel_data_i), .wr_i, .rd_i, .wdata_i,
    .idx_o(idx), .data_wr_o(data_wr), .data_rd_o(data_rd)
  );

  assign osc_run = (a_q[6:4] == OSC_RUN);

  rtc_upd_seq #(.LEAD(UIP_LEAD)) u_seq (
    .clk_i, .rst_ni, .tick_i(sec_tick_i), .run_i(osc_run),
    .step_o, .start_o(start), .refresh_o(refresh)
  );

  assign now_sec = enc_val({1'b0, cnt_sec_i}, b_q[B_BIN]);
  assign now_min = enc_val({1'b0, cnt_min_i}, b_q[B_BIN]);
  assign now_hr  = enc_hour(cnt_hour_i, b_q[B_BIN], b_q[B_H24]);

  rtc_alarm_cmp #(.N(3)) u_alarm (
    .alarm_i({mem[IX_HR_AL], mem[IX_MIN_AL], mem[IX_SEC_AL]}),
    .now_i  ({now_hr, now_min, now_sec}),
    .hit_o  (alarm_hit)
  );

  assign is_time = (idx == I_SEC) || (idx == I_MIN) || (idx == I_HR);
  assign is_ctl  = (idx == I_A) || (idx == I_B) || (idx == I_C) || (idx == I_D);
  assign c_rd    = data_rd && (idx == I_C);

  always_comb begin
    wr_b = wdata_i;
    if (wdata_i[B_SET]) wr_b[B_UPD] = 1'b0;
    b_next = (data_wr && idx == I_B) ? wr_b : b_q;
    if (soft_rst_i) b_next = b_next & ~SOFT_CLR;

    a_next = a_q;
    if (data_wr && idx == I_A) a_next[6:0] = wdata_i[6:0];
    if (start && !b_q[B_SET]) a_next[A_UIP] = 1'b1;
    if (refresh) a_next[A_UIP] = 1'b0;
    if (data_wr && idx == I_B && wdata_i[B_SET]) a_next[A_UIP] = 1'b0;

    // new events win over a same-cycle clear-on-read
    irq_evt = (refresh && b_q[B_UPD]) || (refresh && alarm_hit && b_q[B_ALM]) ||
              (per_tick_i && b_q[B_PER]);
    c_next = c_rd ? 8'h00 : c_q;
    c_next[S_UPD] = c_next[S_UPD] | refresh;
    c_next[S_ALM] = c_next[S_ALM] | (refresh && alarm_hit);
    c_next[S_PER] = c_next[S_PER] | per_tick_i;
    c_next[S_ANY] = c_next[S_ANY] | irq_evt;
    irq_next = (c_rd ? 1'b0 : irq_q) | irq_evt;
    if (soft_rst_i) begin
      c_next   = 8'h00;
      irq_next = 1'b0;
    end

    load_next = (data_wr && is_time && !b_q[B_SET]) ||
                (data_wr && idx == I_B && b_q[B_SET] && !wdata_i[B_SET]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= A_RST;
      b_q    <= B_RST;
      c_q    <= 8'h00;
      d_q    <= D_RST;
      irq_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      a_q    <= a_next;
      b_q    <= b_next;
      c_q    <= c_next;
      irq_q  <= irq_next;
      load_q <= load_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (refresh && !b_q[B_SET]) begin
        mem[IX_SEC] <= now_sec;
        mem[IX_MIN] <= now_min;
        mem[IX_HR]  <= now_hr;
      end
      if (data_wr && !is_ctl) mem[idx] <= wdata_i;
    end
  end

  always_comb begin
    if (!sel_data_i)       rdata_o = 8'hFF;
    else if (idx == I_A)   rdata_o = a_q;
    else if (idx == I_B)   rdata_o = b_q;
    else if (idx == I_C)   rdata_o = c_q;
    else if (idx == I_D)   rdata_o = d_q;
    else                   rdata_o = mem[idx];
  end

  assign load_o      = load_q;
  assign load_sec_o  = 6'(dec_val(mem[IX_SEC], b_q[B_BIN]));
  assign load_min_o  = 6'(dec_val(mem[IX_MIN], b_q[B_BIN]));
  assign load_hour_o = dec_hour(mem[IX_HR], b_q[B_BIN], b_q[B_H24]);
  assign irq_o       = irq_q;
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_o,
  input logic [7:0] c_q,
  input logic [7:0] b_q,
  input logic [7:0] d_q,
  input logic       step_o,
  input logic       osc_run,
  input logic       refresh,
  input logic       c_rd,
  input logic       per_tick_i,
  input logic       soft_rst_i
);
  // R11
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> c_q[7]);

  // R11
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd && !refresh && !per_tick_i) |=> (c_q == 8'h00 && !irq_o));

  // R4
  set_uie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_q[7] |-> !b_q[4]);

  // R3
  valid_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_q == 8'h80);

  // R6
  step_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(osc_run));

  // R10
  upd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh && !soft_rst_i) |=> c_q[4]);
endmodule

bind rtc_regs rtc_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .c_q(c_q), .b_q(b_q), .d_q(d_q),
  .step_o(step_o), .osc_run(osc_run), .refresh(refresh), .c_rd(c_rd),
  .per_tick_i(per_tick_i), .soft_rst_i(soft_rst_i)
);

// File: tb/rtc_regs_test.sv
module rtc_regs_test;
  localparam int LEAD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0, sec_tick = 1'b0, per_tick = 1'b0, soft_rst = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic step, load, irq;
  logic [5:0] ld_sec, ld_min;
  logic [4:0] ld_hour;
  int m_sec = 0, m_min = 0, m_hour = 0, ld_cnt = 0;
  int errors = 0, checks = 0;
  int v;

  always #5 clk = ~clk;

  rtc_regs #(.IDX_W(7), .UIP_LEAD(LEAD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_data_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sec_tick_i(sec_tick), .per_tick_i(per_tick),
    .soft_rst_i(soft_rst), .cnt_sec_i(6'(m_sec)), .cnt_min_i(6'(m_min)),
    .cnt_hour_i(5'(m_hour)), .step_o(step), .load_o(load), .load_sec_o(ld_sec),
    .load_min_o(ld_min), .load_hour_o(ld_hour), .irq_o(irq)
  );

  // external binary time counter
  always @(posedge clk) begin
    if (load) begin
      m_sec <= int'(ld_sec); m_min <= int'(ld_min); m_hour <= int'(ld_hour);
      ld_cnt <= ld_cnt + 1;
    end else if (step) begin
      if (m_sec == 59) begin
        m_sec <= 0;
        if (m_min == 59) begin
          m_min  <= 0;
          m_hour <= (m_hour == 23) ? 0 : m_hour + 1;
        end else m_min <= m_min + 1;
      end else m_sec <= m_sec + 1;
    end
  end

  function automatic int benc(int x, bit bin);
    return bin ? x : (x / 10) * 16 + x % 10;
  endfunction

  function automatic int benc_hr(int h, bit bin, bit h24);
    int h12;
    if (h24) return benc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return benc(h12, bin) | ((h >= 12) ? 128 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(bit s, int d);
    @(negedge clk); sel = s; wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(bit s, output int d);
    @(negedge clk); sel = s; rd = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic reg_wr(int i, int d);
    bus_wr(1'b0, i); bus_wr(1'b1, d);
  endtask

  task automatic reg_rd(int i, output int d);
    bus_wr(1'b0, i); bus_rd(1'b1, d);
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic tick_wait();
    int junk;
    reg_rd(12, junk);
    pulse_tick();
    repeat (LEAD + 3) @(negedge clk);
  endtask

  task automatic set_time(int s, int m, int h, bit bin, bit h24);
    reg_wr(0, benc(s, bin)); reg_wr(2, benc(m, bin)); reg_wr(4, benc_hr(h, bin, h24));
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_time(string req, bit bin, bit h24);
    reg_rd(0, v); chk(req, v, benc(m_sec, bin));
    reg_rd(2, v); chk(req, v, benc(m_min, bin));
    reg_rd(4, v); chk(req, v, benc_hr(m_hour, bin, h24));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lc, seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset values
    reg_rd(10, v); chk("R2 A", v, 'h26);
    reg_rd(11, v); chk("R2 B", v, 'h02);
    reg_rd(12, v); chk("R2 C", v, 'h00);
    reg_rd(13, v); chk("R2 D", v, 'h80);
    chk("R2 irq", int'(irq), 0);
    // R1 index port
    bus_rd(1'b0, v); chk("R1 even read", v, 'hFF);
    bus_wr(1'b0, 'hC0); bus_wr(1'b1, 'h5A);
    reg_rd('h40, v); chk("R1 index 7 bits", v, 'h5A);
    for (int k = 0; k < 8; k++) begin
      int ri, rv;
      ri = 14 + int'($urandom % 114); rv = int'($urandom % 256);
      reg_wr(ri, rv); reg_rd(ri, v); chk("R1 store", v, rv);
    end
    // R3 protected registers
    reg_wr(12, 'hFF); reg_rd(12, v); chk("R3 C write", v, 'h00);
    reg_wr(13, 'h00); reg_rd(13, v); chk("R3 D write", v, 'h80);
    reg_wr(10, 'hA6); reg_rd(10, v); chk("R3 A uip ro", v, 'h26);
    // alarm seconds never matches
    reg_wr(1, 'h7F);
    // R14 load on write
    set_time(59, 59, 23, 1'b0, 1'b1);
    chk("R14 load sec", m_sec, 59); chk("R14 load min", m_min, 59);
    chk("R14 load hour", m_hour, 23);
    // R5 update sequence with UIP
    reg_rd(12, v);
    bus_wr(1'b0, 10);
    pulse_tick();
    bus_rd(1'b1, v); chk("R5 uip set", v, 'hA6);
    repeat (LEAD + 3) @(negedge clk);
    reg_rd(10, v); chk("R5 uip clear", v, 'h26);
    chk_time("R5 refresh", 1'b0, 1'b1);
    chk("R5 wrap hour", m_hour, 0);
    reg_rd(12, v); chk("R10 uf no irq", v, 'h10);
    chk("R10 irq off", int'(irq), 0);
    // R10 / R11 update interrupt and level hold
    reg_wr(11, 'h12);
    tick_wait();
    chk("R10 irq", int'(irq), 1);
    repeat (10) @(negedge clk);
    chk("R11 irq held", int'(irq), 1);
    reg_rd(12, v); chk("R11 C value", v, 'h90);
    chk("R11 irq dropped", int'(irq), 0);
    reg_rd(12, v); chk("R11 C cleared", v, 'h00);
    // R9 alarm
    reg_wr(11, 'h22);
    reg_wr(1, benc(m_sec + 2, 1'b0)); reg_wr(3, 'hC0); reg_wr(5, 'hC0);
    tick_wait();
    reg_rd(12, v); chk("R9 no match", v, 'h10);
    tick_wait();
    chk("R9 alarm irq", int'(irq), 1);
    reg_rd(12, v); chk("R9 alarm flags", v, 'hB0);
    reg_wr(11, 'h02); reg_wr(1, 'hC0);
    tick_wait();
    chk("R9 dontcare no irq", int'(irq), 0);
    reg_rd(12, v); chk("R9 dontcare flag", v, 'h30);
    reg_wr(1, 'h7F);
    // R8 formats
    reg_wr(11, 'h06);
    set_time(5, 58, 13, 1'b1, 1'b1);
    tick_wait();
    chk_time("R8 binary", 1'b1, 1'b1);
    reg_rd(0, v); chk("R8 binary sec", v, 'h06);
    reg_wr(11, 'h00);
    reg_wr(0, 'h10); reg_wr(2, 'h59); reg_wr(4, 'h81);
    repeat (2) @(negedge clk);
    chk("R8 12h pm load", m_hour, 13);
    tick_wait();
    reg_rd(4, v); chk("R8 12h pm", v, 'h81);
    reg_wr(0, 'h59); reg_wr(2, 'h59); reg_wr(4, 'h91);
    tick_wait();
    reg_rd(4, v); chk("R8 12 AM", v, 'h12);
    chk("R8 midnight", m_hour, 0);
    reg_wr(0, 'h59); reg_wr(2, 'h59); reg_wr(4, 'h11);
    tick_wait();
    reg_rd(4, v); chk("R8 12 PM", v, 'h92);
    // R4 / R7 set mode
    reg_wr(11, 'h02);
    set_time(30, 20, 10, 1'b0, 1'b1);
    reg_rd(12, v);
    bus_wr(1'b0, 11);
    pulse_tick();
    bus_wr(1'b1, 'h92);
    reg_rd(10, v); chk("R4 uip cleared", v, 'h26);
    reg_rd(11, v); chk("R4 uie forced", v, 'h82);
    repeat (LEAD + 3) @(negedge clk);
    reg_rd(0, v); chk("R7 frozen", v, 'h30);
    tick_wait();
    reg_rd(0, v); chk("R7 frozen again", v, 'h30);
    chk("R7 counter runs", m_sec, 32);
    chk("R4 no irq", int'(irq), 0);
    reg_rd(12, v); chk("R7 uf in set", v, 'h10);
    lc = ld_cnt;
    reg_wr(0, 'h45);
    repeat (2) @(negedge clk);
    chk("R7 no load", ld_cnt, lc);
    reg_wr(11, 'h02);
    repeat (2) @(negedge clk);
    chk("R7 load on exit", ld_cnt, lc + 1);
    chk("R7 loaded sec", m_sec, 45);
    tick_wait();
    reg_rd(0, v); chk("R7 resumed", v, 'h46);
    // R6 oscillator stopped
    reg_wr(10, 'h06);
    tick_wait();
    chk("R6 no step", m_sec, 46);
    reg_rd(12, v); chk("R6 no flag", v, 'h00);
    reg_wr(10, 'h26);
    // R13 periodic
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    chk("R13 no irq", int'(irq), 0);
    reg_rd(12, v); chk("R13 flag", v, 'h40);
    reg_wr(11, 'h42);
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    chk("R13 irq", int'(irq), 1);
    reg_rd(12, v); chk("R13 flags", v, 'hC0);
    // R12 soft reset
    reg_wr(11, 'h6A);
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk("R12 irq", int'(irq), 0);
    reg_rd(11, v); chk("R12 B", v, 'h02);
    reg_rd(12, v); chk("R12 C", v, 'h00);
    // random formats and times
    for (int k = 0; k < 16; k++) begin
      bit rb, rh;
      int rs, rm, rhr;
      rb = 1'($urandom % 2); rh = 1'($urandom % 2);
      rs = int'($urandom % 60); rm = int'($urandom % 60); rhr = int'($urandom % 24);
      reg_wr(11, (rb ? 4 : 0) | (rh ? 2 : 0));
      set_time(rs, rm, rhr, rb, rh);
      chk("R14 rand load", m_sec * 3600 + m_min * 60 + m_hour, rs * 3600 + rm * 60 + rhr);
      tick_wait();
      chk_time("R8 R5 rand", rb, rh);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule